// File: doc/BRIEF.md
# Smart Card Character Framer with Selectable Coding Convention

This block moves single characters across a half-duplex smart-card data line. The host side is a byte interface: a one-cycle write strobe with a byte to send, and a received byte that comes with a valid pulse and a parity-error flag. The line side is one serial output, one serial input and a sampling tick. The sampling tick fires `TICKS_PER_ETU` times per elementary time unit (one bit period).

A convention select input picks between two codings. The direct coding sends the byte as it is, least significant bit first, with even parity. The inverse coding complements the byte, sends it most significant bit first, and uses odd parity. Both the transmitter and the receiver follow the selected coding.

The block registers the select value only while both directions are idle, so a character always keeps the coding it started with. The link is half duplex. While the transmitter owns the line, the receiver ignores the input. A write that arrives while a character is being received is dropped.

Top module: `sc_char_framer`

## Requirements
- R1: With convention select low (direct), a written byte is sent as one low start bit, then data bits 0 to 7 uninverted, then a parity bit that makes the number of high levels among the nine data and parity bit periods even.
- R2: With convention select high (inverse), a written byte is sent as one low start bit, then the complement of data bits 7 down to 0, then a parity bit that makes the number of high levels among the nine data and parity bit periods odd.
- R3: In direct convention, the received data bits are stored in arrival order from bit 0 up to bit 7, without inversion.
- R4: In inverse convention, the received data bits are stored in arrival order from bit 7 down to bit 0, and then complemented.
- R5: The parity-error flag is high for a received character exactly when its line parity does not match the selected convention: even count of highs for direct, odd count for inverse.
- R6: Every bit period lasts `TICKS_PER_ETU` ticks. After the parity bit, the transmitter keeps the line high and `tx_busy` high for `GUARD_ETU` (default 2) further bit periods. `tx_busy` falls on the tick that ends the last guard period. A write that arrives while `tx_busy` is high has no effect.
- R7: After reset, and whenever `tx_busy` is low, the serial output is high. Out of reset, `tx_busy` and `rx_valid` are low.
- R8: The receiver checks a start bit half a bit period after it detects the low level. If the line is high again at that point, the receiver returns to idle and reports no byte.
- R9: The convention select is taken into the block only while both transmitter and receiver are idle. A change in the middle of a character does not alter that character.
- R10: After the parity bit has been sampled, the receiver raises `rx_valid` for exactly one clock cycle. The byte and the parity-error flag are presented at the same time.
- R11: While the transmitter is busy, a low level on the serial input starts no reception. A write strobe that arrives while a reception is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle enable, `TICKS_PER_ETU` pulses per bit period |
| inverse_sel | input | 1 | Convention select: 0 direct, 1 inverse |
| tx_write | input | 1 | Write strobe for `tx_byte` |
| tx_byte | input | 8 | Byte to send |
| tx_busy | output | 1 | Transmitter is sending a character or its guard time |
| ser_out | output | 1 | Serial line output, high when idle |
| ser_in | input | 1 | Serial line input (asynchronous) |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` and `rx_perr` are updated |
| rx_perr | output | 1 | Parity error of the last received byte |

## Verification
The assertions assume that `sample_tick` never stays high on consecutive cycles for long. They also assume that the serial input holds each bit for a full bit period, so that the receiver is back in its idle or tail state before another character begins. The stimulus keeps within these limits: it raises the tick once every four clocks, drives received characters with bit periods that line up with the tick count, and leaves the line high for several bit periods between characters. Random bytes, conventions and parity corruptions are mixed with directed cases: a select change in mid-character, writes while busy, line noise during transmission, and a short start glitch.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int unsigned CHAR_BITS = 8;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_TAIL
    } rx_state_e;

    // Data bits in line order: index 0 leaves the pin first.
    function automatic logic [CHAR_BITS-1:0] line_order(
        input logic [CHAR_BITS-1:0] data,
        input logic                 inverse
    );
        logic [CHAR_BITS-1:0] r;
        for (int k = 0; k < int'(CHAR_BITS); k++) begin
            r[k] = inverse ? ~data[CHAR_BITS-1-k] : data[k];
        end
        return r;
    endfunction

    // Parity level completing even (direct) or odd (inverse) high count.
    function automatic logic parity_level(
        input logic [CHAR_BITS-1:0] line_bits,
        input logic                 inverse
    );
        return (^line_bits) ^ inverse;
    endfunction

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t q, d;

    always_comb begin
        d = q;
        if (STAGES > 1) begin
            d.chain = {q.chain[STAGES-2:0], async_in};
        end else begin
            d.chain[0] = async_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{chain: '1};
        else        q <= d;
    end

    assign sync_out = q.chain[STAGES-1];
endmodule

// File: rtl/sc_tx.sv
module sc_tx
    import sc_pkg::*;
#(
    parameter int unsigned TICKS_PER_ETU = 8,
    parameter int unsigned GUARD_ETU     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic                 inverse,
    input  logic                 write,
    input  logic [CHAR_BITS-1:0] data,
    input  logic                 rx_idle,
    output logic                 start,
    output logic                 busy,
    output logic                 line_out
);
    localparam int unsigned SUB_W      = (TICKS_PER_ETU > 2) ? $clog2(TICKS_PER_ETU) : 1;
    localparam int unsigned FRAME_BITS = CHAR_BITS + 2;
    localparam int unsigned TOTAL_ETU  = FRAME_BITS + GUARD_ETU;
    localparam int unsigned CNT_W      = $clog2(TOTAL_ETU + 1);

    typedef struct packed {
        logic                  busy;
        logic [SUB_W-1:0]      sub;
        logic [CNT_W-1:0]      etu;
        logic [FRAME_BITS-1:0] shift;
    } tx_regs_t;

    tx_regs_t q, d;
    logic [CHAR_BITS-1:0] ordered;
    logic                 accept;

    always_comb begin
        d       = q;
        ordered = line_order(data, inverse);
        accept  = write && !q.busy && rx_idle;
        if (accept) begin
            d.busy  = 1'b1;
            d.sub   = '0;
            d.etu   = '0;
            d.shift = {parity_level(ordered, inverse), ordered, 1'b0};
        end else if (q.busy && sample_tick) begin
            if (q.sub == SUB_W'(TICKS_PER_ETU - 1)) begin
                d.sub   = '0;
                d.shift = {1'b1, q.shift[FRAME_BITS-1:1]};
                if (q.etu == CNT_W'(TOTAL_ETU - 1)) begin
                    d.busy = 1'b0;
                end else begin
                    d.etu = q.etu + 1'b1;
                end
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sub: '0, etu: '0, shift: '1};
        else        q <= d;
    end

    assign start    = accept;
    assign busy     = q.busy;
    assign line_out = q.shift[0];
endmodule

// File: rtl/sc_rx.sv
module sc_rx
    import sc_pkg::*;
#(
    parameter int unsigned TICKS_PER_ETU = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic                 inverse,
    input  logic                 line_in,
    input  logic                 block,
    output logic                 idle,
    output logic                 valid,
    output logic [CHAR_BITS-1:0] data,
    output logic                 perr
);
    localparam int unsigned SUB_W = (TICKS_PER_ETU > 2) ? $clog2(TICKS_PER_ETU) : 1;
    localparam int unsigned HALF  = TICKS_PER_ETU / 2;
    localparam int unsigned BIT_W = $clog2(CHAR_BITS + 1);

    typedef struct packed {
        rx_state_e            st;
        logic [SUB_W-1:0]     sub;
        logic [BIT_W-1:0]     bitn;
        logic [CHAR_BITS-1:0] shift;
        logic                 valid;
        logic [CHAR_BITS-1:0] data;
        logic                 perr;
    } rx_regs_t;

    rx_regs_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        unique case (q.st)
            RX_IDLE: begin
                if (sample_tick && !line_in && !block) begin
                    d.st  = RX_START;
                    d.sub = '0;
                end
            end
            RX_START: begin
                if (sample_tick) begin
                    if (q.sub == SUB_W'(HALF - 1)) begin
                        d.sub = '0;
                        if (line_in) begin
                            d.st = RX_IDLE;
                        end else begin
                            d.st   = RX_BITS;
                            d.bitn = '0;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            RX_BITS: begin
                if (sample_tick) begin
                    if (q.sub == SUB_W'(TICKS_PER_ETU - 1)) begin
                        d.sub = '0;
                        if (q.bitn == BIT_W'(CHAR_BITS)) begin
                            d.valid = 1'b1;
                            d.perr  = (^q.shift) ^ line_in ^ inverse;
                            d.data  = inverse ? ~q.shift : q.shift;
                            d.st    = RX_TAIL;
                        end else begin
                            d.shift = inverse ? {q.shift[CHAR_BITS-2:0], line_in}
                                              : {line_in, q.shift[CHAR_BITS-1:1]};
                            d.bitn  = q.bitn + 1'b1;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            RX_TAIL: begin
                if (sample_tick && line_in) begin
                    d.st = RX_IDLE;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, sub: '0, bitn: '0, shift: '0,
                   valid: 1'b0, data: '0, perr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign idle  = (q.st == RX_IDLE);
    assign valid = q.valid;
    assign data  = q.data;
    assign perr  = q.perr;
endmodule

// File: rtl/sc_char_framer.sv
module sc_char_framer
    import sc_pkg::*;
#(
    parameter int unsigned TICKS_PER_ETU = 8,
    parameter int unsigned GUARD_ETU     = 2,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick,
    input  logic       inverse_sel,
    input  logic       tx_write,
    input  logic [7:0] tx_byte,
    output logic       tx_busy,
    output logic       ser_out,
    input  logic       ser_in,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_perr
);
    logic conv_q, conv_d;
    logic rx_idle;
    logic tx_start;
    logic line_s;

    always_comb begin
        conv_d = conv_q;
        if (!tx_busy && rx_idle) begin
            conv_d = inverse_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) conv_q <= 1'b0;
        else        conv_q <= conv_d;
    end

    sc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ser_in),
        .sync_out (line_s)
    );

    sc_tx #(.TICKS_PER_ETU(TICKS_PER_ETU), .GUARD_ETU(GUARD_ETU)) i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .inverse     (conv_q),
        .write       (tx_write),
        .data        (tx_byte),
        .rx_idle     (rx_idle),
        .start       (tx_start),
        .busy        (tx_busy),
        .line_out    (ser_out)
    );

    sc_rx #(.TICKS_PER_ETU(TICKS_PER_ETU)) i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .inverse     (conv_q),
        .line_in     (line_s),
        .block       (tx_busy || tx_start),
        .idle        (rx_idle),
        .valid       (rx_valid),
        .data        (rx_byte),
        .perr        (rx_perr)
    );
endmodule

// File: rtl/sc_char_framer_chk.sv
module sc_char_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_busy,
    input logic ser_out,
    input logic rx_valid,
    input logic conv,
    input logic rx_idle
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> ser_out); // R7

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !ser_out); // R1

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R10

    AST_CONV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy || !rx_idle) |=> $stable(conv)); // R9

    AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !rx_valid); // R11
endmodule

bind sc_char_framer sc_char_framer_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_busy  (tx_busy),
    .ser_out  (ser_out),
    .rx_valid (rx_valid),
    .conv     (conv_q),
    .rx_idle  (rx_idle)
);

// File: tb/test_sc_char_framer.sv
`timescale 1ns/1ps
module test_sc_char_framer;
    localparam int OVS  = 8;
    localparam int TDIV = 4;
    localparam int ETU_CYC = OVS * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       inverse_sel = 1'b0;
    logic       tx_write = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_busy;
    logic       ser_out;
    logic       ser_in = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_perr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sc_char_framer #(.TICKS_PER_ETU(OVS), .GUARD_ETU(2), .SYNC_STAGES(2)) i_sc_char_framer (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .inverse_sel(inverse_sel),
        .tx_write(tx_write), .tx_byte(tx_byte), .tx_busy(tx_busy), .ser_out(ser_out),
        .ser_in(ser_in), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_perr(rx_perr)
    );

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % TDIV;
            sample_tick = (tc == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [9:0] frame_bits(input logic [7:0] b, input bit inv, input bit bad);
        logic [9:0] r;
        int ones = 0;
        logic p;
        r[0] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            r[k+1] = inv ? ~b[7-k] : b[k];
            ones += int'(r[k+1]);
        end
        p = inv ? ~ones[0] : ones[0];
        r[9] = bad ? ~p : p;
        return r;
    endfunction

    // mode: 0 plain, 1 select flip mid-character, 2 second write, 3 input noise
    task automatic send_char(input logic [7:0] b, input bit inv, input int mode);
        logic [9:0] exp;
        int n = 0;
        bit seen_valid = 0;
        string rq;
        rq = inv ? "R2" : "R1";
        exp = frame_bits(b, inv, 0);
        inverse_sel = inv;
        repeat (3) step();
        tx_byte = b;
        tx_write = 1'b1;
        step();
        tx_write = 1'b0;
        chk(ser_out == 1'b0 && tx_busy, {rq, " start bit low, busy"}, {ser_out, tx_busy}, 2'b01);
        while (n < 12 * OVS) begin
            step();
            if (rx_valid) seen_valid = 1;
            if (tx_write) tx_write = 1'b0;
            if (sample_tick) begin
                n++;
                if ((n % OVS) == OVS / 2 && n / OVS < 10)
                    chk(ser_out == exp[n / OVS], rq, ser_out, exp[n / OVS]);
                if ((n % OVS) == OVS / 2 && n / OVS >= 10)
                    chk(ser_out && tx_busy, "R6 guard high, busy", {ser_out, tx_busy}, 2'b11);
                if (n == 12 * OVS - 1) chk(tx_busy, "R6 busy before last tick", tx_busy, 1);
                if (n == 12 * OVS) chk(!tx_busy, "R6 busy falls", tx_busy, 0);
                if (mode == 1 && n == 4 * OVS) inverse_sel = ~inv;
                if (mode == 2 && n == 5 * OVS) begin tx_byte = ~b; tx_write = 1'b1; end
                if (mode == 3 && n == 3 * OVS) ser_in = 1'b0;
                if (mode == 3 && n == 6 * OVS) ser_in = 1'b1;
            end
        end
        if (mode == 2) begin
            bit quiet = 1;
            repeat (100) begin step(); if (!ser_out || tx_busy) quiet = 0; end
            chk(quiet, "R6 write while busy ignored", quiet, 1);
        end
        if (mode == 3) begin
            repeat (100) begin step(); if (rx_valid) seen_valid = 1; end
            chk(!seen_valid, "R11 input ignored while sending", seen_valid, 0);
        end
        inverse_sel = inv;
    endtask

    // mode: 0 plain, 1 write during reception, 2 select flip mid-character
    task automatic recv_char(input logic [7:0] b, input bit inv, input bit bad, input int mode);
        logic [9:0] bits;
        int vcount = 0;
        logic [7:0] got = 8'h00;
        logic got_perr = 1'b0;
        bit tx_quiet = 1;
        bits = frame_bits(b, inv, bad);
        inverse_sel = inv;
        repeat (3) step();
        for (int k = 0; k < 10; k++) begin
            ser_in = bits[k];
            for (int c = 0; c < ETU_CYC; c++) begin
                if (mode == 1 && k == 4 && c == 0) begin tx_byte = b; tx_write = 1'b1; end
                if (mode == 2 && k == 3 && c == 0) inverse_sel = ~inv;
                step();
                tx_write = 1'b0;
                if (tx_busy || !ser_out) tx_quiet = 0;
                if (rx_valid) begin vcount++; got = rx_byte; got_perr = rx_perr; end
            end
        end
        ser_in = 1'b1;
        repeat (4 * ETU_CYC) begin
            step();
            if (rx_valid) begin vcount++; got = rx_byte; got_perr = rx_perr; end
        end
        inverse_sel = inv;
        chk(vcount == 1, "R10 one valid cycle", vcount, 1);
        if (inv) chk(got == b, mode == 2 ? "R9 R4 inverse byte" : "R4 inverse byte", got, b);
        else     chk(got == b, mode == 2 ? "R9 R3 direct byte" : "R3 direct byte", got, b);
        chk(got_perr == bad, "R5 parity flag", got_perr, bad);
        if (mode == 1) chk(tx_quiet, "R11 write during reception ignored", tx_quiet, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C5A7));
        repeat (5) step();
        rst_n = 1'b1;
        step();
        chk(ser_out && !tx_busy && !rx_valid, "R7 reset state",
            {ser_out, tx_busy, rx_valid}, 3'b100);

        send_char(8'h3B, 0, 0);
        send_char(8'h3B, 1, 0);
        send_char(8'h00, 1, 0);
        send_char(8'hFF, 0, 0);
        send_char(8'hA5, 0, 1);   // R9 on transmit
        send_char(8'h5C, 1, 1);   // R9 on transmit
        send_char(8'h81, 0, 2);
        send_char(8'h7E, 1, 3);

        recv_char(8'h3B, 0, 0, 0);
        recv_char(8'h3B, 1, 0, 0);
        recv_char(8'hC3, 0, 1, 0);
        recv_char(8'h12, 1, 1, 0);
        recv_char(8'h96, 0, 0, 1);
        recv_char(8'h4D, 1, 0, 2);

        // R8: short start glitch yields no byte, then reception recovers
        begin
            bit seen = 0;
            ser_in = 1'b0;
            repeat (2 * TDIV) step();
            ser_in = 1'b1;
            repeat (300) begin step(); if (rx_valid) seen = 1; end
            chk(!seen, "R8 glitch rejected", seen, 0);
            recv_char(8'h69, 0, 0, 0);
        end

        for (int i = 0; i < 30; i++) begin
            send_char(8'($urandom), 1'($urandom), 0);
            recv_char(8'($urandom), 1'($urandom), ($urandom % 4) == 0, 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule